// File: doc/BRIEF.md
# Lockable Flash Control Register

This block is the control register of an embedded flash controller, together with a key register and a small interrupt-enable register. Software uses it to enable the program buffer, choose and launch sector or bank erases, force a partial buffer write and switch the CRC unit on or off. After reset the configuration is locked. Only a two-word key written to the key register releases it, and any wrong or repeated attempt traps the lock until the next reset.

Once an erase or a forced write is launched, the block presents one request to the flash engine and holds the register bus off until the engine acknowledges it. If an erase would touch protected sectors, the launch is refused and a one-cycle write-protection error pulse is raised instead.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset the control register (word address 1) reads 0x001 (only the lock bit, bit 0, set), the interrupt-enable register (word address 2) reads 0 and busReady is 1.
- R2: While the lock bit is 1, writes to the control register cannot change any bit and writes to the interrupt-enable register have no effect.
- R3: Writing 0x45670123 and then 0xCDEF89AB to the key register (word address 0) clears the lock bit.
- R4: A key write of a wrong value, in the wrong order, or any key write after a completed unlock, sets the lock bit and disables unlocking until reset.
- R5: An unlocked write that sets the lock bit also stores the other control fields (PG bit 1, SER bit 2, BER bit 3, FW bit 4, sector bits 8:6, CRC enable bit 9, all-banks bit 10) in the same write.
- R6: Writing START (bit 5) with BER set raises engReq with engOp 2 (bank), even with SER also set; with only SER it gives engOp 1 (sector) and engSector equal to the sector field.
- R7: START clears when engAck arrives while engReq is high; busReady is 0 from the cycle after the launch until the cycle after the acknowledge, and a write issued meanwhile is held and then applied.
- R8: A sector erase on a sector whose protMask bit is 1, or a bank erase while any protMask bit is 1, does not launch; wrpErr is 1 for exactly the cycle after the write.
- R9: engAllBanks follows the all-banks bit only during a bank erase and is 0 in every other operation.
- R10: Clearing CRC enable while crcBusy is 1 gives a one-cycle crcClr pulse in the next cycle; clearing it while crcBusy is 0 gives none.
- R11: Setting FW requests engOp 3 (force write) after any erase launched in the same write has been acknowledged; FW clears on its own acknowledge.
- R12: Writing START with neither SER nor BER set makes no request, and START reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busSel | input | 1 | Register access valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Word address: 0 key, 1 control, 2 interrupt enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| busReady | output | 1 | Access accepted when high; low while an operation awaits its acknowledge |
| protMask | input | 8 | Per-sector write protection |
| engReq | output | 1 | Operation request to the flash engine |
| engOp | output | 2 | 1 sector erase, 2 bank erase, 3 force write |
| engSector | output | 3 | Target sector of a sector erase |
| engAllBanks | output | 1 | Bank erase covers all banks |
| engAck | input | 1 | Engine acknowledge of the current request |
| wrpErr | output | 1 | Write-protection error pulse |
| pgEn | output | 1 | Program buffer enabled |
| crcEn | output | 1 | CRC unit enabled |
| crcBusy | input | 1 | CRC calculation running |
| crcClr | output | 1 | Reset pulse for the CRC configuration and data |
| ierOut | output | 4 | Interrupt-enable bits |

## Verification
A key state machine that forgets a failed attempt would let a later correct key clear the lock, which shows at the very next control read as bit 0 at 0. A wrong launch decision shows in the cycle after the write: engReq, engOp or wrpErr differ at the ports straight away. A pending flag that does not clear keeps busReady low, so a held write never lands and the following read disagrees, while a flag that clears too early lets the force write appear before the erase is acknowledged.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_SECT = 8;
  localparam int SSN_W    = $clog2(NUM_SECT);
  localparam int CTRL_W   = 11;

  localparam int B_LOCK  = 0;
  localparam int B_PG    = 1;
  localparam int B_SER   = 2;
  localparam int B_BER   = 3;
  localparam int B_FW    = 4;
  localparam int B_START = 5;
  localparam int B_SSN   = 6;
  localparam int B_CRC   = B_SSN + SSN_W;
  localparam int B_ALL   = B_CRC + 1;

  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_IER  = 2'd2;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BANK   = 2'd2,
    OP_FORCE  = 2'd3
  } engOp_e;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_HALF = 2'd1,
    K_USED = 2'd2,
    K_DEAD = 2'd3
  } keyState_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrIer;
    logic unlock;
    logic forceLock;
  } ctlStrb_t;
endpackage

// File: rtl/flash_ctl_ctrl.sv
module flash_ctl_ctrl
  import flash_ctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY1 = 32'h4567_0123,
  parameter logic [DATA_W-1:0] KEY2 = 32'hCDEF_89AB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              pendingIn,
  input  logic              lockIn,
  output ctlStrb_t          strb,
  output logic              busReady
);
  keyState_e keyState, keyNext;
  logic wrAcc, keyWr;

  assign busReady = ~pendingIn;
  assign wrAcc    = busSel & busWr & busReady;
  assign keyWr    = wrAcc & (busAddr == ADDR_KEY);

  always_comb begin
    keyNext        = keyState;
    strb.unlock    = 1'b0;
    strb.forceLock = 1'b0;
    if (keyWr) begin
      unique case (keyState)
        K_IDLE: begin
          if (busWdata == KEY1) keyNext = K_HALF;
          else keyNext = K_DEAD;
        end
        K_HALF: begin
          if (busWdata == KEY2) begin
            keyNext     = K_USED;
            strb.unlock = 1'b1;
          end else begin
            keyNext = K_DEAD;
          end
        end
        K_USED:  keyNext = K_DEAD;
        default: keyNext = K_DEAD;
      endcase
      if (keyNext == K_DEAD && keyState != K_DEAD) strb.forceLock = 1'b1;
    end
  end

  assign strb.wrCtrl = wrAcc & (busAddr == ADDR_CTRL);
  assign strb.wrIer  = wrAcc & (busAddr == ADDR_IER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= K_IDLE;
    else       keyState <= keyNext;
  end

  // R4: a trapped key state never recovers before reset
  a_r4_dead_sticks: assert property (@(posedge clk) disable iff (!rstN)
    keyState == K_DEAD |=> keyState == K_DEAD);
  // R4: a trapped key state always goes with a set lock bit
  a_r4_dead_locked: assert property (@(posedge clk) disable iff (!rstN)
    keyState == K_DEAD |-> lockIn);
  // R3: the lock can only be clear after a completed unlock
  a_r3_clear_needs_key: assert property (@(posedge clk) disable iff (!rstN)
    !lockIn |-> keyState == K_USED);
endmodule

// File: rtl/flash_ctl_dp.sv
module flash_ctl_dp
  import flash_ctl_pkg::*;
#(
  parameter int IER_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrb_t            strb,
  input  logic                busReady,
  input  logic [1:0]          busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                pendingOut,
  output logic                lockOut,
  input  logic [NUM_SECT-1:0] protMask,
  output logic                engReq,
  output logic [1:0]          engOp,
  output logic [SSN_W-1:0]    engSector,
  output logic                engAllBanks,
  input  logic                engAck,
  output logic                wrpErr,
  output logic                pgEn,
  output logic                crcEn,
  input  logic                crcBusy,
  output logic                crcClr,
  output logic [IER_W-1:0]    ierOut
);
  logic lockBit, pgBit, serBit, berBit, fwBit, startBit, crcBit, allBit;
  logic [SSN_W-1:0] ssnReg;
  logic [IER_W-1:0] ierReg;
  logic wrOpen, wdSer, wdBer, wdStart, launchReq, protHit, ackTake;
  logic [SSN_W-1:0] wdSsn;
  logic [CTRL_W-1:0] ctrlView;
  logic unusedWd;
  engOp_e opNow;

  assign unusedWd  = ^busWdata[DATA_W-1:CTRL_W];
  assign wrOpen    = strb.wrCtrl & ~lockBit;
  assign wdSer     = busWdata[B_SER];
  assign wdBer     = busWdata[B_BER];
  assign wdStart   = busWdata[B_START];
  assign wdSsn     = busWdata[B_SSN +: SSN_W];
  assign launchReq = wdStart & (wdSer | wdBer);
  assign protHit   = wdBer ? (|protMask) : protMask[wdSsn];
  assign ackTake   = engAck & engReq;

  always_comb begin
    if (startBit) opNow = berBit ? OP_BANK : OP_SECTOR;
    else if (fwBit) opNow = OP_FORCE;
    else opNow = OP_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBit  <= 1'b1;
      pgBit    <= 1'b0;
      serBit   <= 1'b0;
      berBit   <= 1'b0;
      fwBit    <= 1'b0;
      startBit <= 1'b0;
      crcBit   <= 1'b0;
      allBit   <= 1'b0;
      ssnReg   <= '0;
      ierReg   <= '0;
      wrpErr   <= 1'b0;
      crcClr   <= 1'b0;
    end else begin
      wrpErr <= 1'b0;
      crcClr <= 1'b0;
      if (ackTake) begin
        if (startBit) startBit <= 1'b0;
        else          fwBit    <= 1'b0;
      end
      if (wrOpen) begin
        lockBit  <= busWdata[B_LOCK];
        pgBit    <= busWdata[B_PG];
        serBit   <= wdSer;
        berBit   <= wdBer;
        fwBit    <= busWdata[B_FW];
        ssnReg   <= wdSsn;
        crcBit   <= busWdata[B_CRC];
        allBit   <= busWdata[B_ALL];
        startBit <= launchReq & ~protHit;
        wrpErr   <= launchReq & protHit;
        crcClr   <= crcBit & ~busWdata[B_CRC] & crcBusy;
      end
      if (strb.wrIer && !lockBit) ierReg <= busWdata[IER_W-1:0];
      if (strb.unlock)    lockBit <= 1'b0;
      if (strb.forceLock) lockBit <= 1'b1;
    end
  end

  assign ctrlView = {allBit, crcBit, ssnReg, startBit, fwBit, berBit, serBit, pgBit, lockBit};

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL: busRdata = {{(DATA_W-CTRL_W){1'b0}}, ctrlView};
      ADDR_IER:  busRdata = {{(DATA_W-IER_W){1'b0}}, ierReg};
      default:   busRdata = '0;
    endcase
  end

  assign pendingOut  = startBit | fwBit;
  assign lockOut     = lockBit;
  assign engReq      = pendingOut;
  assign engOp       = opNow;
  assign engSector   = ssnReg;
  assign engAllBanks = allBit & startBit & berBit;
  assign pgEn        = pgBit;
  assign crcEn       = crcBit;
  assign ierOut      = ierReg;

  // R7: the bus is held off whenever a request is outstanding
  a_r7_stall_on_req: assert property (@(posedge clk) disable iff (!rstN)
    engReq |-> !busReady);
  // R6: a sector request never coexists with a stored bank request
  a_r6_bank_wins: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && engOp == OP_SECTOR) |-> !berBit);
  // R8: a refused launch never yields an erase request
  a_r8_err_no_erase: assert property (@(posedge clk) disable iff (!rstN)
    wrpErr |-> !(engReq && engOp != OP_FORCE));
  // R9: all-banks only reaches the engine with a bank erase
  a_r9_allbanks_bank: assert property (@(posedge clk) disable iff (!rstN)
    engAllBanks |-> (engReq && engOp == OP_BANK));
  // R10: the CRC clear is a single-cycle pulse
  a_r10_crcclr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    crcClr |=> !crcClr);
  // R2: a locked register ignores control writes
  a_r2_locked_stable: assert property (@(posedge clk) disable iff (!rstN)
    (lockBit && !strb.unlock && !engReq) |=> $stable(pgBit) && $stable(ssnReg) && $stable(ierReg));
endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import flash_ctl_pkg::*;
#(
  parameter int IER_W = 4,
  parameter logic [31:0] KEY1 = 32'h4567_0123,
  parameter logic [31:0] KEY2 = 32'hCDEF_89AB
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  output logic             busReady,
  input  logic [7:0]       protMask,
  output logic             engReq,
  output logic [1:0]       engOp,
  output logic [2:0]       engSector,
  output logic             engAllBanks,
  input  logic             engAck,
  output logic             wrpErr,
  output logic             pgEn,
  output logic             crcEn,
  input  logic             crcBusy,
  output logic             crcClr,
  output logic [IER_W-1:0] ierOut
);
  ctlStrb_t strb;
  logic pending, lockBit;

  flash_ctl_ctrl #(.KEY1(KEY1), .KEY2(KEY2)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .pendingIn(pending), .lockIn(lockBit),
    .strb(strb), .busReady(busReady)
  );

  flash_ctl_dp #(.IER_W(IER_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busReady(busReady), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pendingOut(pending), .lockOut(lockBit),
    .protMask(protMask), .engReq(engReq), .engOp(engOp), .engSector(engSector),
    .engAllBanks(engAllBanks), .engAck(engAck), .wrpErr(wrpErr), .pgEn(pgEn),
    .crcEn(crcEn), .crcBusy(crcBusy), .crcClr(crcClr), .ierOut(ierOut)
  );
endmodule

// File: tb/flash_ctl_reg_tb.sv
module flash_ctl_reg_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic busReady, engReq, engAllBanks, engAck = 1'b0, wrpErr, pgEn, crcEn, crcClr;
  logic crcBusy = 1'b0;
  logic [7:0] protMask = '0;
  logic [1:0] engOp;
  logic [2:0] engSector;
  logic [3:0] ierOut;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  typedef struct { string req; logic [31:0] exp; logic [31:0] mask; } item_t;
  item_t expQ[$];
  event sampleEv;

  localparam logic [31:0] K1 = 32'h4567_0123, K2 = 32'hCDEF_89AB;

  always #4 clk = ~clk;

  flash_ctl_reg u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .protMask(protMask),
    .engReq(engReq), .engOp(engOp), .engSector(engSector), .engAllBanks(engAllBanks),
    .engAck(engAck), .wrpErr(wrpErr), .pgEn(pgEn), .crcEn(crcEn), .crcBusy(crcBusy),
    .crcClr(crcClr), .ierOut(ierOut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() > 0) begin
        item_t it = expQ.pop_front();
        chk(it.req, busRdata & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic rdExp(logic [1:0] a, logic [31:0] exp, logic [31:0] mask, string req);
    item_t it;
    it.req = req; it.exp = exp; it.mask = mask;
    expQ.push_back(it);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 -> sampleEv;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    while (!busReady) @(negedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic ackOp();
    engAck = 1'b1;
    @(negedge clk);
    engAck = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic unlockSeq();
    wrReg(2'd0, K1);
    wrReg(2'd0, K2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    rdExp(2'd1, 32'h1, 32'hFFFF_FFFF, "R1 ctrl");
    rdExp(2'd2, 32'h0, 32'hFFFF_FFFF, "R1 ier");
    chk("R1 ready", {31'b0, busReady}, 32'h1);

    // R2 locked writes ignored
    wrReg(2'd1, 32'h0000_07FE);
    rdExp(2'd1, 32'h1, 32'hFFFF_FFFF, "R2 ctrl locked");
    chk("R2 no request", {31'b0, engReq}, 32'h0);
    wrReg(2'd2, 32'hF);
    rdExp(2'd2, 32'h0, 32'hFFFF_FFFF, "R2 ier locked");

    // R3 unlock
    unlockSeq();
    rdExp(2'd1, 32'h0, 32'hFFFF_FFFF, "R3 unlocked");

    // R5 relock with fields
    wrReg(2'd1, 32'h0000_0143);
    rdExp(2'd1, 32'h143, 32'hFFFF_FFFF, "R5 relock write");
    chk("R5 pgEn", {31'b0, pgEn}, 32'h1);

    // R4 a repeated unlock stays locked
    unlockSeq();
    rdExp(2'd1, 32'h1, 32'h1, "R4 repeated unlock");

    // R4 wrong order
    doReset();
    wrReg(2'd0, K2);
    unlockSeq();
    rdExp(2'd1, 32'h1, 32'h1, "R4 wrong order");

    // R4 key write after completed unlock forces lock
    doReset();
    unlockSeq();
    rdExp(2'd1, 32'h0, 32'h1, "R4 precondition");
    wrReg(2'd0, K1);
    rdExp(2'd1, 32'h1, 32'h1, "R4 key after unlock");
    wrReg(2'd1, 32'h0000_0002);
    rdExp(2'd1, 32'h1, 32'hFFFF_FFFF, "R4 stays locked");

    // R6 bank priority
    doReset();
    unlockSeq();
    wrReg(2'd1, 32'h0000_00EC);
    chk("R6 req bank", {31'b0, engReq}, 32'h1);
    chk("R6 op bank", {30'b0, engOp}, 32'h2);
    ackOp();
    chk("R7 req cleared", {31'b0, engReq}, 32'h0);
    chk("R7 ready back", {31'b0, busReady}, 32'h1);

    // R6 / R9 sector erase, all-banks ignored
    wrReg(2'd1, 32'h0000_04E4);
    chk("R6 op sector", {30'b0, engOp}, 32'h1);
    chk("R6 sector", {29'b0, engSector}, 32'h3);
    chk("R9 allbanks sector", {31'b0, engAllBanks}, 32'h0);
    ackOp();

    // R9 bank erase with all-banks
    wrReg(2'd1, 32'h0000_0428);
    chk("R9 allbanks bank", {31'b0, engAllBanks}, 32'h1);

    // R7 stall and held write
    chk("R7 stall", {31'b0, busReady}, 32'h0);
    fork
      wrReg(2'd2, 32'h5);
      begin
        @(negedge clk);
        chk("R7 stall c1", {31'b0, busReady}, 32'h0);
        @(negedge clk);
        chk("R7 stall c2", {31'b0, busReady}, 32'h0);
        ackOp();
      end
    join
    rdExp(2'd2, 32'h5, 32'hFFFF_FFFF, "R7 held write");
    rdExp(2'd1, 32'h0, 32'h20, "R7 start cleared");

    // R8 protection
    protMask = 8'h04;
    wrReg(2'd1, 32'h0000_00A4);
    chk("R8 err", {31'b0, wrpErr}, 32'h1);
    chk("R8 no req", {31'b0, engReq}, 32'h0);
    @(negedge clk);
    chk("R8 err pulse", {31'b0, wrpErr}, 32'h0);
    wrReg(2'd1, 32'h0000_0064);
    chk("R8 unprotected sector", {31'b0, engReq}, 32'h1);
    chk("R8 no err", {31'b0, wrpErr}, 32'h0);
    ackOp();
    wrReg(2'd1, 32'h0000_0028);
    chk("R8 bank protected", {31'b0, wrpErr}, 32'h1);
    chk("R8 bank no req", {31'b0, engReq}, 32'h0);
    protMask = 8'h00;

    // R10 CRC clear
    wrReg(2'd1, 32'h0000_0200);
    chk("R10 crcEn", {31'b0, crcEn}, 32'h1);
    crcBusy = 1'b1;
    wrReg(2'd1, 32'h0);
    chk("R10 clr pulse", {31'b0, crcClr}, 32'h1);
    @(negedge clk);
    chk("R10 clr ends", {31'b0, crcClr}, 32'h0);
    crcBusy = 1'b0;
    wrReg(2'd1, 32'h0000_0200);
    wrReg(2'd1, 32'h0);
    chk("R10 idle no clr", {31'b0, crcClr}, 32'h0);

    // R11 force write after erase
    wrReg(2'd1, 32'h0000_0038);
    chk("R11 erase first", {30'b0, engOp}, 32'h2);
    ackOp();
    chk("R11 force req", {31'b0, engReq}, 32'h1);
    chk("R11 force op", {30'b0, engOp}, 32'h3);
    ackOp();
    chk("R11 done", {31'b0, engReq}, 32'h0);
    rdExp(2'd1, 32'h0, 32'h10, "R11 fw cleared");

    // R12 start without erase kind
    wrReg(2'd1, 32'h0000_0020);
    chk("R12 no req", {31'b0, engReq}, 32'h0);
    rdExp(2'd1, 32'h0, 32'h20, "R12 start reads 0");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule